// File: doc/BRIEF.md
# Boolean Pattern Match Engine

The engine watches a small set of input lines and evaluates a sum-of-products Boolean expression over them. It is built from eight slices. Each slice chooses one input line and tests it against a condition: a constant, a level, an edge held until cleared, or an edge in the current cycle only. Consecutive slices are ANDed together into a product term, and a slice flagged as an endpoint closes the term that runs back to the previous endpoint. The last slice always closes a term.

Software sets up the engine through a small register bus with three words: the source selections, the slice configuration, and a read-only status word that reflects the registered match outputs. Input lines pass through a synchroniser before use. A write to the source-select word, even one that repeats the current value, clears every held edge detection, so the same expression can be re-armed.

Top module: `pm_engine`

## Requirements
- R1: After reset every slice condition reads as code 6 (never), all endpoint bits and all source fields read zero, and every match output is low.
- R2: Address 0 holds the source fields, slice i at bits [3i+2:3i], upper bits reading zero. Address 1 holds endpoint bits for slices 0..6 at bits [6:0], bit 7 reading zero, and the condition of slice i at bits [3i+10:3i+8]. Both words read back as written.
- R3: Condition codes 0 (always true), 4 (selected line high), 5 (selected line low) and 6 (never true) evaluate the synchronised line level each cycle.
- R4: A product term is the AND of every slice after the previous endpoint up to and including its own endpoint. It is reported on the match bit of the endpoint slice, and match bits of slices that are not endpoints stay low.
- R5: Slice 7 always closes a term whatever bit 7 of the configuration word holds.
- R6: Codes 1 (rising edge), 2 (falling edge) and 3 (either edge) become true on the matching edge and stay true after the line returns, until the detection state is cleared. An edge of the other direction does not set codes 1 or 2.
- R7: Any write to address 0, including one that writes the current value, clears all held edge detections; the next match result no longer includes them.
- R8: Code 7 is true only in the cycle where an edge of either direction of the selected line is seen, giving a one-cycle match pulse.
- R9: A change on an input line reaches match_o on the third rising clock edge after it is applied. Address 2 returns match_o at bits [15:8] and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Asynchronous input lines the slices select from |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| match_o | output | 8 | Registered product-term match, one bit per endpoint slice |

## Verification
On every cycle the assertions check that held edge detections never drop except right after a source-select write and always drop after one, that no match appears on a slice that was not an endpoint, that slice 7 closes a term of all-true slices, and that an all-never configuration yields no match. The exact latency, the one-cycle shape of the event pulse, the direction sensitivity of held edges, and the grouping of slices into terms under each endpoint pattern show only in the bench scenarios, which sweep all 256 input values under three level-only configurations and compare against an arithmetic model.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int SLICES        = 8;
    localparam int SRC_W         = 3;
    localparam int COND_W        = 3;
    localparam int PINS          = 1 << SRC_W;
    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 2;
    localparam int CFG_COND_BASE = 8;
    localparam int STAT_BASE     = 8;

    typedef enum logic [COND_W-1:0] {
        C_ALWAYS      = 3'd0,
        C_RISE_STICKY = 3'd1,
        C_FALL_STICKY = 3'd2,
        C_EDGE_STICKY = 3'd3,
        C_HIGH        = 3'd4,
        C_LOW         = 3'd5,
        C_NEVER       = 3'd6,
        C_EVENT       = 3'd7
    } cond_e;

    localparam logic [ADDR_W-1:0] A_SRC  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pm_slice.sv
module pm_slice
    import pm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cond_e cond_i,
    input  logic  lvl_i,
    input  logic  rise_i,
    input  logic  fall_i,
    input  logic  clr_i,
    output logic  hit_o
);
    logic sticky_d, sticky_q;
    logic set_w;

    always_comb begin
        set_w = 1'b0;
        hit_o = 1'b0;
        unique case (cond_i)
            C_ALWAYS:      hit_o = 1'b1;
            C_RISE_STICKY: begin set_w = rise_i;          hit_o = sticky_q | set_w; end
            C_FALL_STICKY: begin set_w = fall_i;          hit_o = sticky_q | set_w; end
            C_EDGE_STICKY: begin set_w = rise_i | fall_i; hit_o = sticky_q | set_w; end
            C_HIGH:        hit_o = lvl_i;
            C_LOW:         hit_o = ~lvl_i;
            C_NEVER:       hit_o = 1'b0;
            C_EVENT:       hit_o = rise_i | fall_i;
            default:       hit_o = 1'b0;
        endcase
        sticky_d = clr_i ? 1'b0 : (sticky_q | set_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= 1'b0;
        else        sticky_q <= sticky_d;
    end

    // R6: a held detection survives every cycle without a clear
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sticky_q) && !$past(clr_i)) |-> sticky_q);

    // R7: a clear always empties the held detection
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> !sticky_q);
endmodule

// File: rtl/pm_engine.sv
module pm_engine
    import pm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [SLICES-1:0] match_o
);
    localparam int SRC_BITS  = SLICES * SRC_W;
    localparam int COND_BITS = SLICES * COND_W;
    localparam logic [COND_BITS-1:0] COND_RST = {SLICES{C_NEVER}};

    typedef struct packed {
        logic [SRC_BITS-1:0]  src;
        logic [SLICES-2:0]    ep;
        logic [COND_BITS-1:0] cond;
        logic [PINS-1:0]      prev;
        logic [SLICES-1:0]    match;
    } state_t;

    state_t st_d, st_q;

    logic [PINS-1:0]   pin_s, rise_all, fall_all;
    logic [SLICES-1:0] hit, ends;
    logic              src_clr;

    pm_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    assign rise_all = pin_s & ~st_q.prev;
    assign fall_all = ~pin_s & st_q.prev;
    assign src_clr  = reg_we && (reg_addr == A_SRC);
    assign ends     = {1'b1, st_q.ep};

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        logic [SRC_W-1:0] sel;
        assign sel = st_q.src[g*SRC_W +: SRC_W];
        pm_slice u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond_i (cond_e'(st_q.cond[g*COND_W +: COND_W])),
            .lvl_i  (pin_s[sel]),
            .rise_i (rise_all[sel]),
            .fall_i (fall_all[sel]),
            .clr_i  (src_clr),
            .hit_o  (hit[g])
        );
    end

    always_comb begin
        logic acc;
        st_d      = st_q;
        st_d.prev = pin_s;
        if (reg_we) begin
            case (reg_addr)
                A_SRC: st_d.src = reg_wdata[SRC_BITS-1:0];
                A_CFG: begin
                    st_d.ep   = reg_wdata[SLICES-2:0];
                    st_d.cond = reg_wdata[CFG_COND_BASE +: COND_BITS];
                end
                default: ;
            endcase
        end
        acc = 1'b1;
        for (int i = 0; i < SLICES; i++) begin
            acc           = acc & hit[i];
            st_d.match[i] = ends[i] & acc;
            if (ends[i]) acc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cond <= COND_RST;
        end else begin
            st_q      <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_SRC:  reg_rdata[SRC_BITS-1:0] = st_q.src;
            A_CFG: begin
                reg_rdata[SLICES-2:0]                = st_q.ep;
                reg_rdata[CFG_COND_BASE +: COND_BITS] = st_q.cond;
            end
            A_STAT: reg_rdata[STAT_BASE +: SLICES] = st_q.match;
            default: ;
        endcase
    end

    assign match_o = st_q.match;

    // R4: only slices that were endpoints can report a match
    assert_term_ep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o[SLICES-2:0] & ~$past(st_q.ep)) == '0);

    // R5: the last slice closes a term of all-true slices without an endpoint bit
    assert_last_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.cond) == {SLICES{C_ALWAYS}}) |-> match_o[SLICES-1]);

    // R3: an all-never configuration cannot match
    assert_never_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.cond) == COND_RST) |-> (match_o == '0));
endmodule

// File: tb/tb_pm_engine.sv
module tb_pm_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  match_o;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    localparam logic [23:0] SRC_ID = 24'b111_110_101_100_011_010_001_000;

    always #10 clk = ~clk;

    pm_engine dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .match_o(match_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] cfg_word(input logic [23:0] c, input logic [6:0] ep);
        return {c, 1'b0, ep};
    endfunction

    function automatic logic lvl_val(input logic [2:0] code, input logic b);
        case (code)
            3'd0:    return 1'b1;
            3'd4:    return b;
            3'd5:    return ~b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] model(input logic [23:0] c, input logic [6:0] ep, input logic [7:0] p);
        logic [7:0] m;
        logic acc, e;
        acc = 1'b1;
        for (int i = 0; i < 8; i++) begin
            acc  = acc & lvl_val(c[3*i +: 3], p[i]);
            e    = (i == 7) ? 1'b1 : ep[i];
            m[i] = e & acc;
            if (e) acc = 1'b1;
        end
        return m;
    endfunction

    task automatic sweep(input logic [23:0] c, input logic [6:0] ep);
        wr(2'd1, cfg_word(c, ep));
        wr(2'd0, {8'h0, SRC_ID});
        for (int v = 0; v < 256; v++) begin
            pin_i = v[7:0];
            idle(4);
            check("R3 R4 level sweep", {24'h0, match_o}, {24'h0, model(c, ep, v[7:0])});
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd0, r); check("R1 src reset", r, 32'h0);
        rd(2'd1, r); check("R1 cfg reset", r, {{8{3'd6}}, 8'h00});
        rd(2'd2, r); check("R1 status reset", r, 32'h0);
        check("R1 match reset", {24'h0, match_o}, 32'h0);

        // R2 readback layout
        wr(2'd0, 32'hFFFA_C688); rd(2'd0, r); check("R2 src readback", r, 32'h00FA_C688);
        wr(2'd1, 32'h9876_5455); rd(2'd1, r); check("R2 cfg readback", r, 32'h9876_5455);

        // R3/R4 exhaustive level sweeps
        sweep({3'd4, 3'd5, 3'd6, 3'd4, 3'd4, 3'd0, 3'd5, 3'd4}, 7'b0100101);
        sweep({8{3'd4}}, 7'b0000000);
        sweep({3'd5, 3'd4, 3'd5, 3'd4, 3'd0, 3'd6, 3'd5, 3'd4}, 7'b1111111);

        // R5 slice 7 endpoint is forced, bit 7 ignored
        pin_i = 8'h00;
        wr(2'd1, {{8{3'd0}}, 1'b1, 7'h00});
        rd(2'd1, r); check("R5 bit7 reads zero", r, {{8{3'd0}}, 8'h00});
        idle(3);
        check("R5 single term all slices", {24'h0, match_o}, 32'h80);

        // R6 sticky rising
        wr(2'd1, cfg_word({{7{3'd6}}, 3'd1}, 7'h01));
        wr(2'd0, {8'h0, SRC_ID});
        idle(4);
        check("R6 rise before edge", {24'h0, match_o}, 32'h0);
        pin_i[0] = 1'b1; idle(4);
        check("R6 rise seen", {24'h0, match_o}, 32'h1);
        pin_i[0] = 1'b0; idle(4);
        check("R6 rise held after return", {24'h0, match_o}, 32'h1);

        // R7 same-value source write clears
        wr(2'd0, {8'h0, SRC_ID});
        idle(2);
        check("R7 cleared by src write", {24'h0, match_o}, 32'h0);
        rd(2'd0, r); check("R7 src unchanged", r, {8'h0, SRC_ID});

        // R6 sticky falling ignores rising edge
        wr(2'd1, cfg_word({{7{3'd6}}, 3'd2}, 7'h01));
        wr(2'd0, {8'h0, SRC_ID});
        pin_i[0] = 1'b1; idle(4);
        check("R6 fall ignores rise", {24'h0, match_o}, 32'h0);
        pin_i[0] = 1'b0; idle(4);
        check("R6 fall seen", {24'h0, match_o}, 32'h1);
        pin_i[0] = 1'b1; idle(4);
        check("R6 fall held", {24'h0, match_o}, 32'h1);

        // R6 either edge
        wr(2'd1, cfg_word({{7{3'd6}}, 3'd3}, 7'h01));
        wr(2'd0, {8'h0, SRC_ID});
        idle(4);
        check("R6 either idle", {24'h0, match_o}, 32'h0);
        pin_i[0] = 1'b0; idle(4);
        check("R6 either on fall", {24'h0, match_o}, 32'h1);

        // R8 event pulse
        wr(2'd1, cfg_word({{7{3'd6}}, 3'd7}, 7'h01));
        idle(4);
        pin_i[0] = 1'b1;
        idle(2);
        check("R8 no pulse yet", {24'h0, match_o}, 32'h0);
        idle(1);
        check("R8 pulse rise", {24'h0, match_o}, 32'h1);
        idle(1);
        check("R8 pulse ends", {24'h0, match_o}, 32'h0);
        pin_i[0] = 1'b0;
        idle(3);
        check("R8 pulse fall", {24'h0, match_o}, 32'h1);
        idle(1);
        check("R8 fall pulse ends", {24'h0, match_o}, 32'h0);

        // R9 latency and status mirror
        wr(2'd1, cfg_word({8{3'd4}}, 7'h7F));
        idle(4);
        pin_i = 8'h5A;
        idle(2);
        check("R9 not before third edge", {24'h0, match_o}, 32'h0);
        idle(1);
        check("R9 third edge", {24'h0, match_o}, 32'h5A);
        rd(2'd2, r); check("R9 status word", r, 32'h0000_5A00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule